// File: doc/BRIEF.md
# Rotation Parameter Line Accumulator

This block belongs to the front end of a rotating-background display pipeline. Once per displayed line it reads two parameter sets from a word-addressed video memory table. Each set holds start coordinates, per-line and per-pixel deltas, a 2x3 rotation matrix, a pivot point, a centre point and a coefficient-table start address with its per-line delta. The raw words are decoded into sign-extended 32-bit fields. For each set the block keeps three running accumulators: screen start X, screen start Y and the coefficient-table address. Downstream per-pixel coordinate logic uses these accumulators.

A line fetch starts on a line-start strobe when at least one rotation layer is enabled and the display is not blanked. The sequencer issues one memory read per cycle. The memory returns data one cycle after the read. After the last word lands, every accumulator is updated in a single cycle, either by reloading from the fetched start value or by adding the fetched per-line delta. Per-set control bits pick between the two for each accumulator. On the first display line these bits are forced on, and every completed fetch clears them.

Top module: `rot_line_acc`

## Requirements
- R1: After reset, every accumulator and decoded field output is zero, and `busy_o`, `done_o` and `mem_rd_o` are low.
- R2: A fetch starts only when `line_start_i` is high while idle, `rot_en_i` is non-zero and `blank_i` is low. Otherwise no read is issued and no output changes.
- R3: A fetch reads set 0 and then set 1, 46 consecutive words each, one read per cycle. Word w of set s is read at address ((base with bit 0 cleared) + 64·s + w) modulo 2^18. The 19-bit base is sampled when the fetch starts. Read data arrives one cycle after the read.
- R4: If a fetch is accepted at clock edge E0, `done_o` is high for exactly one cycle, beginning at edge E94. The new accumulator and field values appear at that same edge, and `busy_o` is low again from then on.
- R5: Start X, Y and Z occupy word pairs at offsets 0, 2 and 4, with the high word first. Each value is bits 28..6 of the 32-bit pair, sign-extended.
- R6: The deltas (start-X delta, start-Y delta, pixel X delta, pixel Y delta at pair offsets 6, 8, 10, 12) use bits 18..6 of their pair, sign-extended. The six matrix coefficients, at pair offsets 14 + 2m, use bits 19..6, sign-extended.
- R7: Pivot X/Y/Z sit at single words 0x1A to 0x1C and centre X/Y/Z at 0x1E to 0x20. Each is bits 13..0 of its word, sign-extended.
- R8: The coefficient start (pair 0x2A) is bits 31..6, zero-extended. The coefficient per-line delta (pair 0x2C) is bits 25..6, sign-extended.
- R9: At completion, control bit 0 of a set reloads its X accumulator from start X; otherwise the accumulator adds the start-X delta. Bit 1 does the same for Y. Sums wrap at 32 bits.
- R10: At completion, control bit 2 loads the coefficient accumulator with (3-bit per-set offset << 26) + coefficient start. Otherwise the accumulator adds the coefficient delta.
- R11: When `first_line_i` is high at the accepting edge, all three control bits of both sets become 1 before the fetch.
- R12: `ctl_wr_i` writes the control bits: `ctl_wdata_i[2:0]` for set 0 and `[5:3]` for set 1. Both sets are cleared at the completion edge, and clearing wins over a write in that cycle. Without a fetch the written bits persist.
- R13: While a fetch runs, the accumulator and field outputs keep the previous line's values, and a further `line_start_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tbl_base_i | input | 19 | Parameter table base word address |
| ctl_wr_i | input | 1 | Control bit write strobe |
| ctl_wdata_i | input | 6 | Control bits, set 0 in [2:0], set 1 in [5:3] |
| ka_ofs_i | input | 6 | Coefficient offsets, set 0 in [2:0], set 1 in [5:3] |
| rot_en_i | input | 2 | Rotation layer enables |
| blank_i | input | 1 | Display blanked |
| line_start_i | input | 1 | Start-of-line strobe |
| first_line_i | input | 1 | Current line is display line 0 |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 18 | Memory word address |
| mem_rdata_i | input | 16 | Read data, one cycle after request |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| start_o | output | 2x3x32 | Start X/Y/Z per set |
| delta_o | output | 2x4x32 | Start-X, start-Y, pixel-X, pixel-Y deltas per set |
| mat_o | output | 2x6x32 | Matrix coefficients per set |
| pivot_o | output | 2x3x32 | Pivot X/Y/Z per set |
| centre_o | output | 2x3x32 | Centre X/Y/Z per set |
| ka_start_o | output | 2x32 | Coefficient start per set |
| ka_delta_o | output | 2x32 | Coefficient per-line delta per set |
| acc_x_o | output | 2x32 | Start X accumulator per set |
| acc_y_o | output | 2x32 | Start Y accumulator per set |
| acc_ka_o | output | 2x32 | Coefficient address accumulator per set |

## Verification
The hardest case to reach from the ports is set 1 wrapping past the top of the 18-bit read space while set 0 does not. The stimulus places the base just below 2^19 with bit 0 set, so the masked base, the wrap and the set stride are all exercised in one fetch. Control bits that survive a blanked line are also hard to reach. The stimulus writes them, sends a line start that must be refused, and then sends an enabled line whose outcome shows the bits were kept. A second line start is injected in the middle of a fetch, and the outputs are compared mid-fetch against the previous line's values.

// File: rtl/rot_line_acc_pkg.sv
package rot_line_acc_pkg;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_FETCH,
      FS_DRAIN,
      FS_COMMIT
   } fetch_state_e;

   // word offsets inside one parameter set
   localparam int unsigned WO_XST   = 0;
   localparam int unsigned WO_YST   = 2;
   localparam int unsigned WO_ZST   = 4;
   localparam int unsigned WO_DXST  = 6;
   localparam int unsigned WO_DYST  = 8;
   localparam int unsigned WO_DX    = 10;
   localparam int unsigned WO_DY    = 12;
   localparam int unsigned WO_MAT   = 14;
   localparam int unsigned WO_PIV   = 26;
   localparam int unsigned WO_CTR   = 30;
   localparam int unsigned WO_KAST  = 42;
   localparam int unsigned WO_DKAST = 44;
   localparam int unsigned MIN_SET_WORDS = 46;

   typedef struct packed {
      logic [31:0]      xst;
      logic [31:0]      yst;
      logic [31:0]      zst;
      logic [31:0]      dxst;
      logic [31:0]      dyst;
      logic [31:0]      dx;
      logic [31:0]      dy;
      logic [5:0][31:0] mat;
      logic [2:0][31:0] piv;
      logic [2:0][31:0] ctr;
      logic [31:0]      kast;
      logic [31:0]      dkast;
   } rot_fields_t;

endpackage

// File: rtl/rot_line_fetch.sv
module rot_line_fetch
   import rot_line_acc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 19,
   parameter int unsigned WRAP_W     = 18,
   parameter int unsigned NUM_SETS   = 2,
   parameter int unsigned SET_STRIDE = 64,
   parameter int unsigned SET_WORDS  = 46,
   localparam int unsigned TOTAL     = NUM_SETS * SET_WORDS,
   localparam int unsigned IDX_W     = $clog2(TOTAL),
   localparam int unsigned SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
   localparam int unsigned WRD_W     = $clog2(SET_WORDS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_start_i,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              mem_rd_o,
   output logic [WRAP_W-1:0] mem_addr_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic              start_o,
   output logic              commit_o,
   output logic              busy_o
);

   fetch_state_e      state_q;
   logic [SET_W-1:0]  set_q;
   logic [WRD_W-1:0]  word_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              cap_vld_q;
   logic [IDX_W-1:0]  cap_idx_q;
   logic [ADDR_W-1:0] addr_sum;

   assign start_o  = (state_q == FS_IDLE) && line_start_i && go_i;
   assign busy_o   = (state_q != FS_IDLE);
   assign mem_rd_o = (state_q == FS_FETCH);
   assign commit_o = (state_q == FS_COMMIT);
   assign wr_en_o  = cap_vld_q;
   assign wr_idx_o = cap_idx_q;

   assign addr_sum   = base_q + ADDR_W'(set_q) * ADDR_W'(SET_STRIDE) + ADDR_W'(word_q);
   assign mem_addr_o = addr_sum[WRAP_W-1:0];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q   <= FS_IDLE;
         set_q     <= '0;
         word_q    <= '0;
         idx_q     <= '0;
         base_q    <= '0;
         cap_vld_q <= 1'b0;
         cap_idx_q <= '0;
      end else begin
         cap_vld_q <= (state_q == FS_FETCH);
         cap_idx_q <= idx_q;
         case (state_q)
            FS_IDLE: if (start_o) begin
               state_q <= FS_FETCH;
               set_q   <= '0;
               word_q  <= '0;
               idx_q   <= '0;
               base_q  <= base_i & ~ADDR_W'(1);
            end
            FS_FETCH: begin
               idx_q <= idx_q + 1'b1;
               if (word_q == WRD_W'(SET_WORDS - 1)) begin
                  word_q <= '0;
                  set_q  <= set_q + 1'b1;
               end else begin
                  word_q <= word_q + 1'b1;
               end
               if (idx_q == IDX_W'(TOTAL - 1)) state_q <= FS_DRAIN;
            end
            FS_DRAIN:  state_q <= FS_COMMIT;
            default:   state_q <= FS_IDLE;
         endcase
      end
   end

   // R3
   addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_rd_o && $past(mem_rd_o) && word_q != '0) |->
         mem_addr_o == WRAP_W'($past(mem_addr_o) + 1'b1));

   // R2
   no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !(line_start_i && go_i)) |=> !busy_o);

endmodule

// File: rtl/rot_field_dec.sv
module rot_field_dec
   import rot_line_acc_pkg::*;
#(
   parameter int unsigned SET_WORDS = 46
) (
   input  logic [SET_WORDS-1:0][15:0] words_i,
   output rot_fields_t                fields_o
);

   always_comb begin
      logic [31:0] p;
      fields_o = '0;
      p = {words_i[WO_XST], words_i[WO_XST+1]};
      fields_o.xst = {{9{p[28]}}, p[28:6]};
      p = {words_i[WO_YST], words_i[WO_YST+1]};
      fields_o.yst = {{9{p[28]}}, p[28:6]};
      p = {words_i[WO_ZST], words_i[WO_ZST+1]};
      fields_o.zst = {{9{p[28]}}, p[28:6]};
      p = {words_i[WO_DXST], words_i[WO_DXST+1]};
      fields_o.dxst = {{19{p[18]}}, p[18:6]};
      p = {words_i[WO_DYST], words_i[WO_DYST+1]};
      fields_o.dyst = {{19{p[18]}}, p[18:6]};
      p = {words_i[WO_DX], words_i[WO_DX+1]};
      fields_o.dx = {{19{p[18]}}, p[18:6]};
      p = {words_i[WO_DY], words_i[WO_DY+1]};
      fields_o.dy = {{19{p[18]}}, p[18:6]};
      for (int m = 0; m < 6; m++) begin
         p = {words_i[WO_MAT + 2*m], words_i[WO_MAT + 2*m + 1]};
         fields_o.mat[m] = {{18{p[19]}}, p[19:6]};
      end
      for (int i = 0; i < 3; i++) begin
         fields_o.piv[i] = {{18{words_i[WO_PIV+i][13]}}, words_i[WO_PIV+i][13:0]};
         fields_o.ctr[i] = {{18{words_i[WO_CTR+i][13]}}, words_i[WO_CTR+i][13:0]};
      end
      p = {words_i[WO_KAST], words_i[WO_KAST+1]};
      fields_o.kast = {6'd0, p[31:6]};
      p = {words_i[WO_DKAST], words_i[WO_DKAST+1]};
      fields_o.dkast = {{12{p[25]}}, p[25:6]};
   end

endmodule

// File: rtl/rot_set_accum.sv
module rot_set_accum
   import rot_line_acc_pkg::*;
#(
   parameter int unsigned OFS_W    = 3,
   parameter int unsigned KA_SHIFT = 26
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             commit_i,
   input  logic [2:0]       ctl_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  rot_fields_t      new_i,
   output logic [31:0]      acc_x_o,
   output logic [31:0]      acc_y_o,
   output logic [31:0]      acc_ka_o
);

   logic [31:0] ka_reload;
   assign ka_reload = (32'(ofs_i) << KA_SHIFT) + new_i.kast;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_x_o  <= '0;
         acc_y_o  <= '0;
         acc_ka_o <= '0;
      end else if (commit_i) begin
         acc_x_o  <= ctl_i[0] ? new_i.xst : acc_x_o  + new_i.dxst;
         acc_y_o  <= ctl_i[1] ? new_i.yst : acc_y_o  + new_i.dyst;
         acc_ka_o <= ctl_i[2] ? ka_reload : acc_ka_o + new_i.dkast;
      end
   end

   // R13
   acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> ($stable(acc_x_o) && $stable(acc_y_o) && $stable(acc_ka_o)));

endmodule

// File: rtl/rot_line_acc.sv
module rot_line_acc
   import rot_line_acc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 19,
   parameter int unsigned WRAP_W     = 18,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_SETS   = 2,
   parameter int unsigned SET_STRIDE = 64,
   parameter int unsigned SET_WORDS  = 46,
   parameter int unsigned OFS_W      = 3,
   parameter int unsigned KA_SHIFT   = 26,
   localparam int unsigned TOTAL     = NUM_SETS * SET_WORDS,
   localparam int unsigned IDX_W     = $clog2(TOTAL),
   localparam int unsigned CTL_W     = 3
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic [ADDR_W-1:0]                 tbl_base_i,
   input  logic                              ctl_wr_i,
   input  logic [NUM_SETS*CTL_W-1:0]         ctl_wdata_i,
   input  logic [NUM_SETS*OFS_W-1:0]         ka_ofs_i,
   input  logic [1:0]                        rot_en_i,
   input  logic                              blank_i,
   input  logic                              line_start_i,
   input  logic                              first_line_i,
   output logic                              mem_rd_o,
   output logic [WRAP_W-1:0]                 mem_addr_o,
   input  logic [DATA_W-1:0]                 mem_rdata_i,
   output logic                              busy_o,
   output logic                              done_o,
   output logic [NUM_SETS-1:0][2:0][31:0]    start_o,
   output logic [NUM_SETS-1:0][3:0][31:0]    delta_o,
   output logic [NUM_SETS-1:0][5:0][31:0]    mat_o,
   output logic [NUM_SETS-1:0][2:0][31:0]    pivot_o,
   output logic [NUM_SETS-1:0][2:0][31:0]    centre_o,
   output logic [NUM_SETS-1:0][31:0]         ka_start_o,
   output logic [NUM_SETS-1:0][31:0]         ka_delta_o,
   output logic [NUM_SETS-1:0][31:0]         acc_x_o,
   output logic [NUM_SETS-1:0][31:0]         acc_y_o,
   output logic [NUM_SETS-1:0][31:0]         acc_ka_o
);

   if (DATA_W != 16) begin : g_bad_data_w
      $error("rot_line_acc: DATA_W must be 16");
   end
   if (SET_WORDS < MIN_SET_WORDS || SET_WORDS > SET_STRIDE) begin : g_bad_words
      $error("rot_line_acc: SET_WORDS out of range");
   end
   if (WRAP_W > ADDR_W || OFS_W + KA_SHIFT > 32) begin : g_bad_widths
      $error("rot_line_acc: inconsistent widths");
   end

   logic                             start, commit, wr_en;
   logic [IDX_W-1:0]                 wr_idx;
   logic [TOTAL-1:0][DATA_W-1:0]     shadow_q;
   logic [NUM_SETS-1:0][CTL_W-1:0]   ctl_q;
   logic                             done_q;

   rot_line_fetch #(
      .ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .NUM_SETS(NUM_SETS),
      .SET_STRIDE(SET_STRIDE), .SET_WORDS(SET_WORDS)
   ) fetch_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
      .go_i((|rot_en_i) && !blank_i), .base_i(tbl_base_i),
      .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .wr_en_o(wr_en),
      .wr_idx_o(wr_idx), .start_o(start), .commit_o(commit), .busy_o(busy_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) shadow_q <= '0;
      else if (wr_en) shadow_q[wr_idx] <= mem_rdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                     ctl_q <= '0;
      else if (commit)                 ctl_q <= '0;
      else if (start && first_line_i)  ctl_q <= '1;
      else if (ctl_wr_i)               ctl_q <= ctl_wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) done_q <= 1'b0;
      else         done_q <= commit;
   end
   assign done_o = done_q;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      rot_fields_t fnew, fq;

      rot_field_dec #(.SET_WORDS(SET_WORDS)) dec_i (
         .words_i(shadow_q[s*SET_WORDS +: SET_WORDS]),
         .fields_o(fnew)
      );

      always_ff @(posedge clk_i) begin
         if (!rst_ni)     fq <= '0;
         else if (commit) fq <= fnew;
      end

      rot_set_accum #(.OFS_W(OFS_W), .KA_SHIFT(KA_SHIFT)) acc_i (
         .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .ctl_i(ctl_q[s]),
         .ofs_i(ka_ofs_i[s*OFS_W +: OFS_W]), .new_i(fnew),
         .acc_x_o(acc_x_o[s]), .acc_y_o(acc_y_o[s]), .acc_ka_o(acc_ka_o[s])
      );

      assign start_o[s]    = {fq.zst, fq.yst, fq.xst};
      assign delta_o[s]    = {fq.dy, fq.dx, fq.dyst, fq.dxst};
      assign mat_o[s]      = fq.mat;
      assign pivot_o[s]    = fq.piv;
      assign centre_o[s]   = fq.ctr;
      assign ka_start_o[s] = fq.kast;
      assign ka_delta_o[s] = fq.dkast;
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R12
   ctl_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ctl_q == '0);

   // R11
   first_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(busy_o) && $past(first_line_i)) |-> (&ctl_q));

endmodule

// File: tb/rot_line_acc_tb_top.sv
module rot_line_acc_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic [18:0]       tbl_base = '0;
   logic              ctl_wr = 1'b0;
   logic [5:0]        ctl_wdata = '0;
   logic [5:0]        ka_ofs = 6'b010_101;
   logic [1:0]        rot_en = 2'b01;
   logic              blank = 1'b0;
   logic              line_start = 1'b0;
   logic              first_line = 1'b0;
   logic              mem_rd;
   logic [17:0]       mem_addr;
   logic [15:0]       mem_rdata = '0;
   logic              busy, done;
   logic [1:0][2:0][31:0] start_w;
   logic [1:0][3:0][31:0] delta_w;
   logic [1:0][5:0][31:0] mat_w;
   logic [1:0][2:0][31:0] piv_w, ctr_w;
   logic [1:0][31:0]      ka_w, dka_w, accx_w, accy_w, acck_w;

   rot_line_acc dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tbl_base_i(tbl_base), .ctl_wr_i(ctl_wr),
      .ctl_wdata_i(ctl_wdata), .ka_ofs_i(ka_ofs), .rot_en_i(rot_en), .blank_i(blank),
      .line_start_i(line_start), .first_line_i(first_line), .mem_rd_o(mem_rd),
      .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
      .start_o(start_w), .delta_o(delta_w), .mat_o(mat_w), .pivot_o(piv_w),
      .centre_o(ctr_w), .ka_start_o(ka_w), .ka_delta_o(dka_w), .acc_x_o(accx_w),
      .acc_y_o(accy_w), .acc_ka_o(acck_w)
   );

   int n_chk = 0, n_fail = 0, salt = 1, cyc = 0;
   bit done_flag = 0;

   function automatic logic [15:0] memword(int a);
      int t;
      t = a * 40503 + salt * 7919;
      return 16'(t ^ (t >>> 7));
   endfunction

   always @(posedge clk) mem_rdata <= memword(int'(mem_addr));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] sx(longint v, int bits);
      longint m;
      m = v & ((longint'(1) << bits) - 1);
      if (((m >> (bits - 1)) & 1) != 0) m = m - (longint'(1) << bits);
      return m[31:0];
   endfunction

   // reference model state
   bit m_busy = 0, m_done = 0;
   int m_cnt = 0;
   int m_base = 0;
   logic [2:0]  m_ctl [2];
   logic [31:0] m_start [2][3], m_delta [2][4], m_mat [2][6], m_piv [2][3], m_ctr [2][3];
   logic [31:0] m_ka [2], m_dka [2], m_ax [2], m_ay [2], m_ak [2];

   task automatic m_reset();
      m_busy = 0; m_done = 0; m_cnt = 0; m_base = 0;
      for (int s = 0; s < 2; s++) begin
         m_ctl[s] = 0; m_ka[s] = 0; m_dka[s] = 0; m_ax[s] = 0; m_ay[s] = 0; m_ak[s] = 0;
         for (int i = 0; i < 3; i++) begin m_start[s][i] = 0; m_piv[s][i] = 0; m_ctr[s][i] = 0; end
         for (int i = 0; i < 4; i++) m_delta[s][i] = 0;
         for (int i = 0; i < 6; i++) m_mat[s][i] = 0;
      end
   endtask

   task automatic m_commit();
      for (int s = 0; s < 2; s++) begin
         longint w [46];
         for (int j = 0; j < 46; j++) w[j] = longint'(memword((m_base + s*64 + j) & 'h3FFFF));
         for (int i = 0; i < 3; i++) m_start[s][i] = sx(((w[2*i] << 16) | w[2*i+1]) >> 6, 23);
         for (int i = 0; i < 4; i++) m_delta[s][i] = sx(((w[6+2*i] << 16) | w[7+2*i]) >> 6, 13);
         for (int i = 0; i < 6; i++) m_mat[s][i] = sx(((w[14+2*i] << 16) | w[15+2*i]) >> 6, 14);
         for (int i = 0; i < 3; i++) begin m_piv[s][i] = sx(w[26+i], 14); m_ctr[s][i] = sx(w[30+i], 14); end
         m_ka[s]  = 32'(((w[42] << 16) | w[43]) >> 6);
         m_dka[s] = sx(((w[44] << 16) | w[45]) >> 6, 20);
         m_ax[s] = m_ctl[s][0] ? m_start[s][0] : m_ax[s] + m_delta[s][0];
         m_ay[s] = m_ctl[s][1] ? m_start[s][1] : m_ay[s] + m_delta[s][1];
         m_ak[s] = m_ctl[s][2] ? (32'(ka_offset(s)) << 26) + m_ka[s] : m_ak[s] + m_dka[s];
      end
   endtask

   function automatic int ka_offset(int s);
      return (s == 0) ? int'(ka_ofs[2:0]) : int'(ka_ofs[5:3]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == 94) begin
               m_commit(); m_busy = 0; m_done = 1; m_ctl[0] = 0; m_ctl[1] = 0;
            end else if (ctl_wr) begin
               m_ctl[0] = ctl_wdata[2:0]; m_ctl[1] = ctl_wdata[5:3];
            end
         end else if (line_start && rot_en != 0 && !blank) begin
            m_busy = 1; m_cnt = 0; m_base = int'(tbl_base) & 'h7FFFE;
            if (first_line) begin m_ctl[0] = 3'b111; m_ctl[1] = 3'b111; end
            else if (ctl_wr) begin m_ctl[0] = ctl_wdata[2:0]; m_ctl[1] = ctl_wdata[5:3]; end
         end else if (ctl_wr) begin
            m_ctl[0] = ctl_wdata[2:0]; m_ctl[1] = ctl_wdata[5:3];
         end
      end
   end

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         bit erd;
         erd = m_busy && m_cnt < 92;
         chk("R4 busy", 32'(busy), 32'(m_busy));
         chk("R4 done", 32'(done), 32'(m_done));
         chk("R3 rd", 32'(mem_rd), 32'(erd));
         if (erd)
            chk("R3 addr", 32'(mem_addr),
                32'((m_base + (m_cnt / 46) * 64 + (m_cnt % 46)) & 'h3FFFF));
         for (int s = 0; s < 2; s++) begin
            chk("R9 accx", accx_w[s], m_ax[s]);
            chk("R9 accy", accy_w[s], m_ay[s]);
            chk("R10 accka", acck_w[s], m_ak[s]);
            for (int i = 0; i < 3; i++) chk("R5 start", start_w[s][i], m_start[s][i]);
            for (int i = 0; i < 4; i++) chk("R6 delta", delta_w[s][i], m_delta[s][i]);
            for (int i = 0; i < 6; i++) chk("R6 mat", mat_w[s][i], m_mat[s][i]);
            for (int i = 0; i < 3; i++) begin
               chk("R7 pivot", piv_w[s][i], m_piv[s][i]);
               chk("R7 centre", ctr_w[s][i], m_ctr[s][i]);
            end
            chk("R8 kast", ka_w[s], m_ka[s]);
            chk("R8 dkast", dka_w[s], m_dka[s]);
         end
      end
   end

   task automatic do_line(bit first, logic [18:0] base, bit poke_mid);
      @(negedge clk);
      line_start = 1'b1; first_line = first; tbl_base = base;
      @(negedge clk);
      line_start = 1'b0; first_line = 1'b0;
      if (poke_mid) begin
         logic [31:0] hold_x;
         repeat (40) @(negedge clk);
         hold_x = accx_w[0];
         line_start = 1'b1; tbl_base = 19'h00100;
         @(negedge clk);
         line_start = 1'b0;
         // R13: mid-fetch outputs still hold previous line, second strobe ignored
         chk("R13 hold", accx_w[0], hold_x);
         chk("R13 busy", 32'(busy), 32'd1);
      end
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ctl(logic [5:0] v);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   initial begin : stim
      logic [31:0] px;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 rd", 32'(mem_rd), 0);
      chk("R1 accx", accx_w[0], 0);
      chk("R1 accka", acck_w[1], 0);
      chk("R1 start", start_w[1][2], 0);

      // R2: blanked and disabled strobes start nothing
      blank = 1'b1;
      do_line(1'b1, 19'h00040, 1'b0);
      chk("R2 blank", accx_w[0], 0);
      blank = 1'b0; rot_en = 2'b00;
      do_line(1'b0, 19'h00040, 1'b0);
      chk("R2 disabled", 32'(busy), 0);
      rot_en = 2'b10;

      // R11 + R3 wrap: odd base near top of space, set 1 wraps to 0
      do_line(1'b1, 19'h7FFC1, 1'b0);
      chk("R11 reload x", accx_w[1], start_w[1][0]);
      chk("R11 reload ka", acck_w[0], (32'd5 << 26) + ka_w[0]);

      // R12: bits cleared, next line accumulates; R13 strobe during fetch
      salt = 2;
      px = accx_w[0];
      do_line(1'b0, 19'h12345, 1'b1);
      chk("R12 cleared", accx_w[0], px + delta_w[0][0]);

      // R12: written bits survive a refused strobe, then act
      salt = 3;
      wr_ctl(6'b101_010);
      blank = 1'b1;
      do_line(1'b0, 19'h00200, 1'b0);
      blank = 1'b0;
      do_line(1'b0, 19'h00200, 1'b0);
      chk("R12 kept y", accy_w[0], start_w[0][1]);
      chk("R12 kept ka1", acck_w[1], (32'd2 << 26) + ka_w[1]);

      salt = 4;
      rot_en = 2'b11;
      do_line(1'b0, 19'h3FFF0, 1'b0);
      salt = 5;
      do_line(1'b1, 19'h0ABCD, 1'b0);
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done_flag) begin
         done_flag = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule